// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides an unsigned 2N-bit dividend by an unsigned N-bit divisor. It returns an N-bit quotient and an N-bit remainder, and it produces one quotient bit per clock. The dividend is loaded into a joined high/low register pair. On every cycle the pair shifts left by one bit. A single N+2-bit adder then forms the shifted high part minus the divisor. The carry out of that adder picks, through a multiplexer, what is written back: either the difference or the plain shifted value. The same carry becomes the new quotient bit. Apart from an iteration counter, the block needs no sequencing logic.

A caller pulses `start_i` while the block is idle. `busy_o` then stays high for the N iterations. `done_o` pulses for one cycle when the results are ready on `quotient_o` and `remainder_o`. The block checks the operands when it loads them. If the quotient would not fit in N bits, which includes a divisor of zero, it skips the iterations and raises `ovf_o`.

Top module: `restoring_divider`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `ovf_o` are low and `quotient_o` and `remainder_o` are zero.
- R2: A `start_i` that is sampled while the block is idle and does not overflow drives `busy_o` high for exactly N cycles. `done_o` is high in the cycle right after the last busy cycle, and only in that cycle, unless a new start arrives.
- R3: On a completed division, `quotient_o` equals floor(dividend / divisor).
- R4: On a completed division, `remainder_o` equals dividend mod divisor, and this value is always less than the divisor.
- R5: When the upper N bits of the dividend are greater than or equal to the divisor (a zero divisor included), `done_o` and `ovf_o` are high in the cycle after the start edge and `busy_o` never rises. In that case `quotient_o` shows the lower N bits of the dividend and `remainder_o` shows the upper N bits.
- R6: While `busy_o` is high, `start_i` and new operand values are ignored. The results that follow belong to the operands accepted at the original start.
- R7: During an iteration, if the bit shifted out of the top of the high half is 1, the subtraction is always taken and the new quotient bit is 1. The comparison is made at N+1 bits.
- R8: Each accepted start that does not overflow clears `ovf_o`, so `ovf_o` is low when that division completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| dividend_i | input | 2N | Unsigned dividend |
| divisor_i | input | N | Unsigned divisor |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ovf_o | output | 1 | Quotient overflow or divide by zero |
| quotient_o | output | N | Quotient (low register) |
| remainder_o | output | N | Remainder (high register) |

## Verification
The bench builds the divider with N=4, so the dividend has 8 bits and the divisor has 4. At that size every one of the 4096 dividend/divisor pairs can be run. The sweep covers every overflow case, every zero divisor, and every path in which the shifted-out top bit forces the subtraction. Each pair also checks the exact latency and the one-cycle width of the done pulse. A separate scenario sends a second start while a division is running.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} rdiv_state_e;
endpackage

// File: rtl/rdiv_step.sv
module rdiv_step #(
  parameter int N = 16
) (
  input  logic [N-1:0] ac_i,
  input  logic [N-1:0] mq_i,
  input  logic [N-1:0] dvs_i,
  output logic [N-1:0] ac_o,
  output logic [N-1:0] mq_o,
  output logic         take_o
);
  localparam int W = N + 1;

  logic [W-1:0] shl_hi;
  logic [W:0]   sum;

  // high half after shift, keeping the bit shifted out of it
  assign shl_hi = {ac_i, mq_i[N-1]};
  // a - b as a + ~b + 1; carry out means a >= b
  assign sum    = {1'b0, shl_hi} + {1'b0, ~{1'b0, dvs_i}} + {{W{1'b0}}, 1'b1};
  assign take_o = sum[W];
  assign ac_o   = take_o ? sum[N-1:0] : shl_hi[N-1:0];
  assign mq_o   = {mq_i[N-2:0], take_o};
endmodule

// File: rtl/rdiv_range.sv
module rdiv_range #(
  parameter int N = 16
) (
  input  logic [N-1:0] hi_i,
  input  logic [N-1:0] dvs_i,
  output logic         ovf_o
);
  logic [N:0] sum;

  assign sum   = {1'b0, hi_i} + {1'b0, ~dvs_i} + {{N{1'b0}}, 1'b1};
  assign ovf_o = sum[N];
endmodule

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
  import rdiv_pkg::*;
#(
  parameter int N = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ovf_in_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o,
  output logic ovf_o
);
  localparam int CW = $clog2(N + 1);

  rdiv_state_e   state_q;
  logic [CW-1:0] cnt_q;

  assign busy_o = (state_q == ST_RUN);
  assign step_o = busy_o;
  assign load_o = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
      ovf_o   <= 1'b0;
    end else if (load_o) begin
      ovf_o  <= ovf_in_i;
      done_o <= ovf_in_i;
      if (!ovf_in_i) begin
        state_q <= ST_RUN;
        cnt_q   <= CW'(N);
      end
    end else if (busy_o) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        state_q <= ST_IDLE;
        done_o  <= 1'b1;
      end
    end else begin
      done_o <= 1'b0;
    end
  end

  // R2
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R2
  done_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R5
  ovf_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> !busy_o);
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int N = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [2*N-1:0] dividend_i,
  input  logic [N-1:0]   divisor_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           ovf_o,
  output logic [N-1:0]   quotient_o,
  output logic [N-1:0]   remainder_o
);
  logic [N-1:0] ac_q, mq_q, dvs_q;
  logic [N-1:0] ac_nxt, mq_nxt;
  logic         take, load, step, ovf_in;

  rdiv_range #(.N(N)) i_range (
    .hi_i  (dividend_i[2*N-1:N]),
    .dvs_i (divisor_i),
    .ovf_o (ovf_in)
  );

  rdiv_ctrl #(.N(N)) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .ovf_in_i (ovf_in),
    .load_o   (load),
    .step_o   (step),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .ovf_o    (ovf_o)
  );

  rdiv_step #(.N(N)) i_step (
    .ac_i   (ac_q),
    .mq_i   (mq_q),
    .dvs_i  (dvs_q),
    .ac_o   (ac_nxt),
    .mq_o   (mq_nxt),
    .take_o (take)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q  <= '0;
      mq_q  <= '0;
      dvs_q <= '0;
    end else if (load) begin
      ac_q  <= dividend_i[2*N-1:N];
      mq_q  <= dividend_i[N-1:0];
      dvs_q <= divisor_i;
    end else if (step) begin
      ac_q <= ac_nxt;
      mq_q <= mq_nxt;
    end
  end

  assign quotient_o  = mq_q;
  assign remainder_o = ac_q;

  // R6
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(dvs_q));
  // R7
  carry_forces_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ac_q[N-1]) |=> mq_q[0]);
  // R4
  rem_below_dvs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ovf_o) |-> (remainder_o < dvs_q));
endmodule

// File: tb/test_restoring_divider.sv
module test_restoring_divider;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [2*N-1:0] dividend = '0;
  logic [N-1:0]   divisor = '0;
  logic           busy, done, ovf;
  logic [N-1:0]   quo, rem;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  restoring_divider #(.N(N)) i_restoring_divider (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .dividend_i  (dividend),
    .divisor_i   (divisor),
    .busy_o      (busy),
    .done_o      (done),
    .ovf_o       (ovf),
    .quotient_o  (quo),
    .remainder_o (rem)
  );

  task automatic chk(string req, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(int dvd, int dvs);
    int  lat;
    bit  eovf;
    int  busy_cnt;
    eovf = ((dvd >> N) >= dvs);
    @(negedge clk);
    dividend = dvd[2*N-1:0];
    divisor  = dvs[N-1:0];
    start    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    busy_cnt = 0;
    while (!done && lat < 20) begin
      if (busy) busy_cnt++;
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    if (eovf) begin
      chk("R5", lat, 0, "overflow latency");
      chk("R5", int'(ovf), 1, "ovf flag");
      chk("R5", busy_cnt, 0, "busy during overflow");
      chk("R5", int'(quo), dvd % (1 << N), "low half shown");
      chk("R5", int'(rem), dvd >> N, "high half shown");
    end else begin
      chk("R2", lat, N, "latency");
      chk("R2", busy_cnt, N, "busy cycles");
      chk("R8", int'(ovf), 0, "ovf cleared");
      chk("R3", int'(quo), dvd / dvs, "quotient");
      chk("R4", int'(rem), dvd % dvs, "remainder");
    end
    @(posedge clk);
    @(negedge clk);
    chk("R2", int'(done), 0, "done width");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", int'(busy), 0, "busy at reset");
    chk("R1", int'(done), 0, "done at reset");
    chk("R1", int'(ovf), 0, "ovf at reset");
    chk("R1", int'(quo), 0, "quotient at reset");
    chk("R1", int'(rem), 0, "remainder at reset");
    rst_n = 1'b1;

    // R3 R4 R5 R7 R8: every operand pair
    for (int d = 0; d < (1 << N); d++)
      for (int v = 0; v < (1 << (2 * N)); v++)
        run(v, d);

    // R6: second start while busy is ignored
    @(negedge clk);
    dividend = 8'h5C;
    divisor  = 4'd7;
    start    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    @(posedge clk);
    @(negedge clk);
    dividend = 8'hFF;
    divisor  = 4'd1;
    start    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (!done) begin
      @(posedge clk);
      @(negedge clk);
    end
    chk("R6", int'(quo), 13, "quotient after ignored start");
    chk("R6", int'(rem), 1, "remainder after ignored start");
    chk("R6", int'(ovf), 0, "ovf after ignored start");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule